// File: doc/BRIEF.md
# Palettized five-to-four line downscaler

This block narrows one scanline of 8-bit palette indices by a factor of five to four while converting it to 15-bit RGB colour. Each accepted index is resolved through a 256-entry colour table held inside the block. The resulting colours are taken in groups of five, and each group becomes four output pixels. Three of the four outputs are weighted blends of neighbouring colours. The fourth is a straight copy. A 320-pixel line leaves the block as a 256-pixel line.

Indices enter over a valid/ready handshake that carries a start-of-line marker. Colours leave over a second valid/ready handshake and mark the first pixel of a line. The colour table is loaded through a simple write port. Weighting is done on the packed 15-bit word. The low bits of each channel are cleared before every shift, so no bit crosses from one channel into its neighbour. The weights never span two groups, and nothing carries from one group into the next.

Top module: `pal_line_downscale`

## Requirements
- R1: Every five consecutive accepted indices after a line start (p0..p4) produce exactly four output pixels (r0..r3) in that order; a 320-index line produces 256 outputs.
- R2: Each 5-bit channel of r0 (red bits 4:0, green 9:5, blue 14:10) equals ((a^b)>>2) + ((a&~b)>>1) + (a&b), with a the channel of colour p0 and b the channel of colour p1 (a three-to-one weighting).
- R3: Each channel of r1 equals floor((p1 + p2) / 2).
- R4: Each channel of r2 follows the R2 expression with a taken from p3 and b taken from p2.
- R5: Bits 14:0 of r3 equal bits 14:0 of the colour of p4.
- R6: A table write with the write enable high at a clock edge stores the 16-bit data at the 8-bit address. Every index accepted at a later edge resolves to that data.
- R7: Bit 15 of every output pixel is zero, whatever bit 15 of the table entry holds.
- R8: An index accepted with the start-of-line input high is taken as p0. Any group it interrupts produces no further outputs, and outputs already delivered from that group stay valid.
- R9: The output start-of-line flag is 1 exactly on the r0 of a group whose p0 was accepted with start-of-line high, and 0 on every other output.
- R10: While out_valid is high and out_ready is low, out_pixel and out_sol hold their values, out_valid stays high, and in_ready is low.
- R11: With out_ready held high, in_ready stays high, so a full line is accepted at one index per clock. An output appears two clock edges after the index that completes it is accepted.
- R12: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_we | input | 1 | Colour table write enable |
| pal_waddr | input | 8 | Colour table write address |
| pal_wdata | input | 16 | Colour table write data (bit 15 unused in outputs) |
| in_valid | input | 1 | Index valid |
| in_ready | output | 1 | Block can accept an index this cycle |
| in_index | input | 8 | Palette index |
| in_sol | input | 1 | Index is the first of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 16 | Output colour, x BBBBB GGGGG RRRRR |
| out_sol | output | 1 | Output pixel is the first of a line |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a stalled output holds steady and blocks input, that bit 15 stays clear, and that a new output always follows an accepted index two edges earlier. The arithmetic of the three blend phases and the pass-through is shown only by the scenarios. So are the restart of a group on a start-of-line index, the placement of the output line marker, and the 320-to-256 count. In those scenarios a queue model predicts each pixel from the table contents. The scenarios use table entries chosen so that the per-channel weighting truncates differently from an exact division.

// File: rtl/dsc_pkg.sv
// Package: shared widths, the group phase type and the packed-word colour
// blend functions used by the downscaler. Assumes three channels of equal
// width packed with red in the least significant field.
package dsc_pkg;

    localparam int CH_W   = 5;
    localparam int NUM_CH = 3;
    localparam int RGB_W  = CH_W * NUM_CH;

    typedef logic [RGB_W-1:0] rgb_t;

    typedef enum logic [2:0] {
        PH_P0 = 3'd0,
        PH_P1 = 3'd1,
        PH_P2 = 3'd2,
        PH_P3 = 3'd3,
        PH_P4 = 3'd4
    } phase_e;

    // Purpose: step the group phase, wrapping after the fifth pixel.
    function automatic phase_e phase_step(phase_e p);
        if (p == PH_P4) return PH_P0;
        return phase_e'(3'(p) + 3'd1);
    endfunction

    // Purpose: build a mask that selects the lowest nbits of every channel.
    function automatic rgb_t chan_low_mask(int unsigned nbits);
        rgb_t m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int b = 0; b < CH_W; b++) begin
                if (b < int'(nbits)) m[c*CH_W + b] = 1'b1;
            end
        end
        return m;
    endfunction

    // Purpose: per-channel floor average of two packed colours.
    function automatic rgb_t blend_half(rgb_t a, rgb_t b);
        rgb_t m1;
        m1 = chan_low_mask(1);
        return (((a ^ b) & ~m1) >> 1) + (a & b);
    endfunction

    // Purpose: per-channel three-to-one weighting of packed colours, a heavy.
    function automatic rgb_t blend_quarter(rgb_t a, rgb_t b);
        rgb_t m1;
        rgb_t m2;
        m1 = chan_low_mask(1);
        m2 = chan_low_mask(2);
        return (((a ^ b) & ~m2) >> 2) + (((a & ~b) & ~m1) >> 1) + (a & b);
    endfunction

endpackage

// File: rtl/pal_ram.sv
// Colour table: one write port and one registered read port.
// Assumes a read and a write to the same address in the same cycle return
// the old contents. The read register holds while rd_en is low.
module pal_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store a table entry on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Purpose: registered lookup, held when not enabled.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/phase_track.sv
// Input side: tags each accepted index with its position in the group of
// five, restarting at p0 on a start-of-line index. Its outputs line up with
// the colour table read data one cycle later. Assumes adv gates every stage.
module phase_track
    import dsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  logic   accept,
    input  logic   in_sol,
    output logic   s1_valid,
    output phase_e s1_phase,
    output logic   s1_sol
);
    phase_e phase_q;
    phase_e pix_phase;

    // Purpose: a start-of-line index is always p0, else continue the count.
    always_comb begin
        pix_phase = in_sol ? PH_P0 : phase_q;
    end

    // Purpose: advance the group counter on each accepted index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_P0;
        end else if (accept) begin
            phase_q <= phase_step(pix_phase);
        end
    end

    // Purpose: stage register aligned with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_phase <= PH_P0;
            s1_sol   <= 1'b0;
        end else if (adv) begin
            s1_valid <= accept;
            if (accept) begin
                s1_phase <= pix_phase;
                s1_sol   <= in_sol;
            end
        end
    end
endmodule

// File: rtl/blend_stage.sv
// Output side: keeps the previous colour of the group and forms r0..r3
// from it and the current colour. p0 produces nothing. Assumes adv is
// high whenever the output register may be overwritten.
module blend_stage
    import dsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  logic   s1_valid,
    input  phase_e s1_phase,
    input  logic   s1_sol,
    input  rgb_t   colour,
    output logic   out_valid,
    output rgb_t   out_rgb,
    output logic   out_sol
);
    rgb_t prev_q;
    logic line_pend_q;
    rgb_t mix;

    // Purpose: choose the weighting for the current group position.
    always_comb begin
        unique case (s1_phase)
            PH_P1:   mix = blend_quarter(prev_q, colour);
            PH_P2:   mix = blend_half(prev_q, colour);
            PH_P3:   mix = blend_quarter(colour, prev_q);
            default: mix = colour;
        endcase
    end

    // Purpose: remember the last colour and whether this group opens a line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            line_pend_q <= 1'b0;
        end else if (adv && s1_valid) begin
            prev_q <= colour;
            if (s1_phase == PH_P0)      line_pend_q <= s1_sol;
            else if (s1_phase == PH_P1) line_pend_q <= 1'b0;
        end
    end

    // Purpose: output register; loads only when the downstream slot is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
            out_sol   <= 1'b0;
        end else if (adv) begin
            out_valid <= s1_valid && (s1_phase != PH_P0);
            if (s1_valid && (s1_phase != PH_P0)) begin
                out_rgb <= mix;
                out_sol <= (s1_phase == PH_P1) && line_pend_q;
            end
        end
    end
endmodule

// File: rtl/pal_line_downscale.sv
// Top: palette lookup followed by five-to-four horizontal blending.
// One global advance signal stalls the whole pipeline when the output is
// held. Assumes PAL_W is at least the packed colour width.
module pal_line_downscale
    import dsc_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int PAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_we,
    input  logic [IDX_W-1:0] pal_waddr,
    input  logic [PAL_W-1:0] pal_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_index,
    input  logic             in_sol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAL_W-1:0] out_pixel,
    output logic             out_sol
);
    localparam int PAD_W = PAL_W - RGB_W;

    logic             adv;
    logic             accept;
    logic [PAL_W-1:0] pal_rdata;
    logic             s1_valid;
    phase_e           s1_phase;
    logic             s1_sol;
    rgb_t             out_rgb;

    // Purpose: the pipeline moves whenever the output slot is empty or drained.
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv;
        accept   = in_valid && adv;
    end

    pal_ram #(.ADDR_W(IDX_W), .DATA_W(PAL_W)) u_pal (
        .clk     (clk),
        .wr_en   (pal_we),
        .wr_addr (pal_waddr),
        .wr_data (pal_wdata),
        .rd_en   (accept),
        .rd_addr (in_index),
        .rd_data (pal_rdata)
    );

    phase_track u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .accept   (accept),
        .in_sol   (in_sol),
        .s1_valid (s1_valid),
        .s1_phase (s1_phase),
        .s1_sol   (s1_sol)
    );

    blend_stage u_blend (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .s1_valid  (s1_valid),
        .s1_phase  (s1_phase),
        .s1_sol    (s1_sol),
        .colour    (pal_rdata[RGB_W-1:0]),
        .out_valid (out_valid),
        .out_rgb   (out_rgb),
        .out_sol   (out_sol)
    );

    // Purpose: widen the colour to the port, forcing the spare bits to zero.
    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^pal_rdata[PAL_W-1:RGB_W];
            assign out_pixel = {{PAD_W{1'b0}}, out_rgb};
        end else begin : g_nopad
            assign out_pixel = out_rgb[PAL_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pal_line_downscale_chk.sv
// Checker: handshake and output-format properties of the downscaler,
// attached to every instance of the top module.
module pal_line_downscale_chk #(
    parameter int PAL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PAL_W-1:0] out_pixel,
    input logic             out_sol
);
    // R7: top bit of every delivered pixel is clear
    assert_pixel_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pixel[PAL_W-1] == 1'b0));

    // R10: a refused output stays on the port unchanged
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_sol)));

    // R10: a refused output blocks the input
    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R11: a new output needs an index accepted two edges earlier
    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));
endmodule

bind pal_line_downscale pal_line_downscale_chk #(.PAL_W(PAL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .out_sol   (out_sol)
);

// File: tb/tb_pal_line_downscale.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each accepted index and queues the
// expected pixels; a monitor pops and compares every delivered pixel.
module tb_pal_line_downscale;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_waddr = '0;
    logic [15:0] pal_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic        in_sol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_pixel;
    logic        out_sol;

    always #HALF clk = ~clk;

    pal_line_downscale dut (
        .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_sol(in_sol), .out_valid(out_valid),
        .out_ready(out_ready), .out_pixel(out_pixel), .out_sol(out_sol)
    );

    typedef struct {
        logic [15:0] px;
        logic        sol;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] pal_m [256];
    int          m_phase = 0;
    logic [14:0] m_prev = '0;
    logic        m_pend = 1'b0;
    int          checks = 0;
    int          fails = 0;
    int          out_cnt = 0;
    int          stall_cnt = 0;
    bit          bp_on = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    int          cycles = 0;

    function automatic logic [14:0] ref_quarter(logic [14:0] a, logic [14:0] b);
        logic [14:0] r;
        for (int ch = 0; ch < 3; ch++) begin
            int x, y, v;
            x = int'(a[ch*5 +: 5]);
            y = int'(b[ch*5 +: 5]);
            v = ((x ^ y) >> 2) + (((x & ~y) & 31) >> 1) + (x & y);
            r[ch*5 +: 5] = v[4:0];
        end
        return r;
    endfunction

    function automatic logic [14:0] ref_half(logic [14:0] a, logic [14:0] b);
        logic [14:0] r;
        for (int ch = 0; ch < 3; ch++) begin
            int v;
            v = (int'(a[ch*5 +: 5]) + int'(b[ch*5 +: 5])) / 2;
            r[ch*5 +: 5] = v[4:0];
        end
        return r;
    endfunction

    task automatic push_exp(logic [14:0] v, logic s, string t);
        exp_t e;
        e.px = {1'b0, v};
        e.sol = s;
        e.tag = t;
        q.push_back(e);
    endtask

    // Model one accepted index (R1..R5, R8, R9).
    task automatic model(logic [7:0] idx, logic s);
        logic [14:0] c;
        int ph;
        c = pal_m[idx][14:0];
        ph = s ? 0 : m_phase;
        case (ph)
            0: m_pend = s;
            1: begin push_exp(ref_quarter(m_prev, c), m_pend, "R2"); m_pend = 1'b0; end
            2: push_exp(ref_half(m_prev, c), 1'b0, "R3");
            3: push_exp(ref_quarter(c, m_prev), 1'b0, "R4");
            default: push_exp(c, 1'b0, "R5");
        endcase
        m_prev = c;
        m_phase = (ph + 1) % 5;
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic write_pal(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        pal_we = 1'b1; pal_waddr = a; pal_wdata = d;
        @(negedge clk);
        pal_we = 1'b0;
        pal_m[a] = d;
    endtask

    task automatic send(logic [7:0] idx, logic s);
        @(negedge clk);
        in_valid = 1'b1; in_index = idx; in_sol = s;
        forever begin
            #5;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        model(idx, s);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Output ready pattern, changed only at falling edges.
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= bp_on ? lfsr[0] : 1'b1;
    end

    // Monitor: samples shortly before each rising edge.
    initial begin
        bit          was_stalled = 1'b0;
        logic [15:0] held = '0;
        forever begin
            @(negedge clk);
            #8;
            if (rst_n) begin
                if (in_valid && !in_ready) stall_cnt++;
                if (was_stalled)
                    check(out_valid && out_pixel == held, "R10", "held pixel",
                          int'(out_pixel), int'(held));
                if (out_valid && out_ready) begin
                    out_cnt++;
                    if (q.size() == 0) begin
                        check(1'b0, "R1", "unexpected output", int'(out_pixel), 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(out_pixel == e.px, e.tag, "pixel", int'(out_pixel), int'(e.px));
                        check(out_sol == e.sol, "R9", "line flag", int'(out_sol), int'(e.sol));
                        check(out_pixel[15] == 1'b0, "R7", "bit 15", int'(out_pixel[15]), 0);
                    end
                end
                was_stalled = out_valid && !out_ready;
                held = out_pixel;
            end
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    task automatic run_tests();
        // R12: reset state
        repeat (3) @(negedge clk);
        #5;
        check(out_valid == 1'b0, "R12", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R12", "in_ready in reset", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(out_valid == 1'b0, "R12", "out_valid after reset", int'(out_valid), 0);

        // R6: load the table, some entries with bit 15 set
        for (int i = 0; i < 256; i++)
            write_pal(8'(i), 16'((i * 16'h2F1B) ^ (i << 7)));
        write_pal(8'd1, 16'h8C63);
        write_pal(8'd2, 16'h0000);
        write_pal(8'd3, 16'h7FFF);
        write_pal(8'd4, 16'h0421);

        // R1, R11: full line at full rate
        out_cnt = 0; stall_cnt = 0;
        for (int i = 0; i < 320; i++) send(8'((i * 7 + 3) % 256), i == 0);
        idle();
        drain();
        check(out_cnt == 256, "R1", "outputs per 320 line", out_cnt, 256);
        check(stall_cnt == 0, "R11", "stalled cycles", stall_cnt, 0);

        // R2, R4, R7: channel values that truncate unevenly
        send(8'd1, 1'b1); send(8'd2, 1'b0); send(8'd3, 1'b0); send(8'd2, 1'b0); send(8'd1, 1'b0);
        send(8'd3, 1'b1); send(8'd4, 1'b0); send(8'd1, 1'b0); send(8'd4, 1'b0); send(8'd3, 1'b0);
        idle();
        drain();

        // R8: interrupted groups
        send(8'd10, 1'b1); send(8'd11, 1'b0); send(8'd12, 1'b0);
        send(8'd20, 1'b1);
        for (int i = 0; i < 6; i++) send(8'(30 + i), 1'b0);
        send(8'd40, 1'b1);
        for (int i = 0; i < 4; i++) send(8'(50 + i), 1'b0);
        idle();
        drain();
        check(q.size() == 0, "R8", "queue empty after restarts", q.size(), 0);

        // R10: full line with random backpressure
        bp_on = 1'b1;
        out_cnt = 0;
        for (int i = 0; i < 320; i++) send(8'((i * 13 + 5) % 256), i == 0);
        idle();
        drain();
        bp_on = 1'b0;
        check(out_cnt == 256, "R1", "outputs under backpressure", out_cnt, 256);

        // R6: rewrite entries and reuse them
        write_pal(8'd7, 16'h1234);
        write_pal(8'd8, 16'hFEDC);
        for (int i = 0; i < 10; i++) send((i % 2) ? 8'd8 : 8'd7, i == 0);
        idle();
        drain();
        check(q.size() == 0, "R6", "queue empty", q.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                wait (cycles >= 150000);
                check(1'b0, "R1", "watchdog expired", cycles, 150000);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule